// File: doc/BRIEF.md
# Spiking Pointer-Map Attention Network

This block is a clocked digital model of a small recurrent spiking network used for attentional selection. Nine integrate-and-fire map neurons receive sensory spike strobes. Two pointer neurons receive top-down attention strobes. The pointers sit inside the recurrent loop. Each pointer drives every map neuron through a per-neuron weight: one pointer uses a cosine-shaped profile and the other a sine-shaped profile. Map spikes flow back to the pointers through the same weights. The pointer pair therefore steers excitation toward one region of the map.

Competition among map neurons comes from inhibition, which runs in one of two modes. In global mode, a shared inhibitory neuron counts map spikes, and its spike clears every map neuron, the one that caused it included. In mutual mode, each map spike clears every other map neuron but leaves its sender alone. This lets an attended, weaker input hold its activity after the attention input is removed.

Every neuron has a 12-bit saturating membrane, a programmable threshold and a programmable refractory count. A spike produced on one clock edge reaches its targets on the next edge.

Top module: `spk_attn_net`

## Requirements
- R1: While `rst_n` is low, all spike outputs are low, all membranes and refractory counters are zero, and every coupling weight is zero.
- R2: On an edge where `sens_spk[j]` is high, map neuron j adds `sens_wt` to its membrane. When the sum reaches `thresh` (sum >= `thresh`), `map_spk[j]` is high after that same edge, and the membrane returns to zero.
- R3: The membrane sum saturates at 4095 rather than wrapping. With `thresh` = 4095 and `sens_wt` = 255, a map neuron stays silent for 16 sensory spikes and fires on the 17th.
- R4: After a neuron fires, it ignores all excitation for the next `refr` edges. On the edge after that it integrates again.
- R5: A pointer spike from edge t excites map neuron j on edge t+1, by that neuron's cosine entry (pointer 0) or sine entry (pointer 1). This applies only while `en_p2m` is 1.
- R6: A map spike from edge t excites pointer 0 by that map neuron's cosine entry and pointer 1 by its sine entry on edge t+1. The contributions of all spiking map neurons are summed, and `att_wt` is added for an attention strobe. Map input to the pointers applies only while `en_m2p` is 1.
- R7: Global mode (`mode_mutual` = 0, `en_inh` = 1): the inhibitory neuron adds `inh_wt` per map spike of the previous edge. Its spike from edge t sets every map membrane to zero on edge t+1, the originating neuron included, and no map neuron fires on that edge.
- R8: Mutual mode (`mode_mutual` = 1, `en_inh` = 1): a spike of map neuron i from edge t sets every other map membrane to zero on edge t+1, and none of them fires then. Neuron i itself keeps integrating.
- R9: With `en_inh` = 0, map spikes never clear other map neurons. With `en_p2m` = 0, pointer spikes leave the map membranes unchanged.
- R10: When `cfg_we` is high, the cosine and sine entries for map neuron `cfg_idx` are written. An index of 9 or more writes nothing.
- R11: In mutual mode the inhibitory neuron never spikes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sens_spk | input | 9 | Sensory spike strobes, bit j to map neuron j |
| att_spk | input | 2 | Attention spike strobes, bit k to pointer k |
| cfg_we | input | 1 | Weight table write strobe |
| cfg_idx | input | 4 | Map neuron index for a table write |
| cfg_cos | input | 8 | Cosine-profile weight to write |
| cfg_sin | input | 8 | Sine-profile weight to write |
| sens_wt | input | 8 | Weight of a sensory spike |
| att_wt | input | 8 | Weight of an attention spike |
| inh_wt | input | 8 | Weight of a map spike onto the inhibitory neuron |
| thresh | input | 12 | Firing threshold for all neurons |
| refr | input | 4 | Refractory length in clock cycles |
| en_p2m | input | 1 | Enable pointer-to-map coupling |
| en_m2p | input | 1 | Enable map-to-pointer coupling |
| en_inh | input | 1 | Enable inhibition |
| mode_mutual | input | 1 | 1: inhibit-all-but-self, 0: global inhibitory neuron |
| map_spk | output | 9 | Map neuron spike strobes |
| ptr_spk | output | 2 | Pointer neuron spike strobes |
| inh_spk | output | 1 | Global inhibitory neuron spike strobe |

## Verification
The bench targets the difference between the two inhibition modes through a neuron that has integrated again after its own spike. A design that spared the sender in global mode, or cleared it in mutual mode, would fire one edge early or one edge late. It saturates a membrane past 4095: a wrapping adder would fall to a small value and never fire. It counts the ignored edges after a spike, which exposes an off-by-one refractory window. It writes the weight table at an out-of-range index that would alias onto entry 3: an aliased write would make that neuron fire on a sine-weighted pointer spike it should barely feel. Disabled couplings are checked by showing that a neuron holding a partial membrane does not fire.

// File: rtl/spk_attn_net.sv
module spk_attn_net #(
  parameter int N_MAP = 9,
  parameter int WW    = 8,
  parameter int MW    = 12,
  parameter int RW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_MAP-1:0]         sens_spk,
  input  logic [1:0]               att_spk,
  input  logic                     cfg_we,
  input  logic [$clog2(N_MAP)-1:0] cfg_idx,
  input  logic [WW-1:0]            cfg_cos,
  input  logic [WW-1:0]            cfg_sin,
  input  logic [WW-1:0]            sens_wt,
  input  logic [WW-1:0]            att_wt,
  input  logic [WW-1:0]            inh_wt,
  input  logic [MW-1:0]            thresh,
  input  logic [RW-1:0]            refr,
  input  logic                     en_p2m,
  input  logic                     en_m2p,
  input  logic                     en_inh,
  input  logic                     mode_mutual,
  output logic [N_MAP-1:0]         map_spk,
  output logic [1:0]               ptr_spk,
  output logic                     inh_spk
);
  localparam int IW   = $clog2(N_MAP);
  localparam int XW   = WW + $clog2(N_MAP + 2) + 1;
  localparam int SUMW = ((XW > MW) ? XW : MW) + 1;
  localparam int SW   = 1 + MW + RW;
  localparam logic [MW-1:0] MAXV = {MW{1'b1}};

  logic [WW-1:0] cos_w [N_MAP];
  logic [WW-1:0] sin_w [N_MAP];
  logic [MW-1:0] mmem [N_MAP];
  logic [RW-1:0] mref [N_MAP];
  logic [MW-1:0] pmem [2];
  logic [RW-1:0] pref [2];
  logic [MW-1:0] imem;
  logic [RW-1:0] iref;
  logic [XW-1:0] pexc [2];
  logic [XW-1:0] iexc;
  logic          glob_kill;

  function automatic logic [SW-1:0] nstep(input logic [MW-1:0] m, input logic [RW-1:0] c,
                                          input logic [XW-1:0] x, input logic kill);
    logic [SUMW-1:0] s;
    logic [RW-1:0]   cd;
    cd = (c != '0) ? c - RW'(1) : c;
    if (kill) return {1'b0, {MW{1'b0}}, cd};
    if (c != '0) return {1'b0, m, cd};
    s = SUMW'(m) + SUMW'(x);
    if (s > SUMW'(MAXV)) s = SUMW'(MAXV);
    if (s >= SUMW'(thresh)) return {1'b1, {MW{1'b0}}, refr};
    return {1'b0, s[MW-1:0], c};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N_MAP; j++) begin
        cos_w[j] <= '0;
        sin_w[j] <= '0;
      end
    end else if (cfg_we && cfg_idx < IW'(N_MAP)) begin
      cos_w[cfg_idx] <= cfg_cos;
      sin_w[cfg_idx] <= cfg_sin;
    end
  end

  always_comb begin
    pexc[0] = att_spk[0] ? XW'(att_wt) : '0;
    pexc[1] = att_spk[1] ? XW'(att_wt) : '0;
    iexc    = '0;
    for (int j = 0; j < N_MAP; j++) begin
      if (map_spk[j] && en_m2p) begin
        pexc[0] = pexc[0] + XW'(cos_w[j]);
        pexc[1] = pexc[1] + XW'(sin_w[j]);
      end
      if (map_spk[j] && en_inh && !mode_mutual) iexc = iexc + XW'(inh_wt);
    end
  end

  assign glob_kill = en_inh && !mode_mutual && inh_spk;

  for (genvar j = 0; j < N_MAP; j++) begin : g_map
    logic [XW-1:0] exc;
    logic          kill;
    logic [SW-1:0] nx;
    assign exc = (sens_spk[j] ? XW'(sens_wt) : '0)
               + ((en_p2m && ptr_spk[0]) ? XW'(cos_w[j]) : '0)
               + ((en_p2m && ptr_spk[1]) ? XW'(sin_w[j]) : '0);
    assign kill = glob_kill ||
                  (en_inh && mode_mutual && ((map_spk & ~(N_MAP'(1) << j)) != '0));
    assign nx = nstep(mmem[j], mref[j], exc, kill);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mmem[j]    <= '0;
        mref[j]    <= '0;
        map_spk[j] <= 1'b0;
      end else begin
        {map_spk[j], mmem[j], mref[j]} <= nx;
      end
    end

    p_refr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (map_spk[j] && $past(refr) != '0) |=> !map_spk[j]);
  end

  for (genvar k = 0; k < 2; k++) begin : g_ptr
    logic [SW-1:0] nx;
    assign nx = nstep(pmem[k], pref[k], pexc[k], 1'b0);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pmem[k]    <= '0;
        pref[k]    <= '0;
        ptr_spk[k] <= 1'b0;
      end else begin
        {ptr_spk[k], pmem[k], pref[k]} <= nx;
      end
    end
  end

  logic [SW-1:0] inx;
  assign inx = nstep(imem, iref, iexc, mode_mutual);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imem    <= '0;
      iref    <= '0;
      inh_spk <= 1'b0;
    end else begin
      {inh_spk, imem, iref} <= inx;
    end
  end

  p_global_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_inh && !mode_mutual && inh_spk) |-> (map_spk == '0));

  p_mutual_spare_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_inh && mode_mutual) && $onehot($past(map_spk))) |-> ((map_spk & ~$past(map_spk)) == '0));

  p_mutual_inh_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_mutual) |-> !inh_spk);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (map_spk == '0 && ptr_spk == '0 && !inh_spk));

endmodule

// File: tb/spk_attn_net_tb.sv
module spk_attn_net_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] sens_spk = '0;
  logic [1:0] att_spk = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_cos = '0, cfg_sin = '0;
  logic [7:0] sens_wt = '0, att_wt = '0, inh_wt = '0;
  logic [11:0] thresh = 12'd100;
  logic [3:0] refr = '0;
  logic       en_p2m = 1'b0, en_m2p = 1'b0, en_inh = 1'b0, mode_mutual = 1'b0;
  logic [8:0] map_spk;
  logic [1:0] ptr_spk;
  logic       inh_spk;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spk_attn_net u_dut (
    .clk(clk), .rst_n(rst_n), .sens_spk(sens_spk), .att_spk(att_spk),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cos(cfg_cos), .cfg_sin(cfg_sin),
    .sens_wt(sens_wt), .att_wt(att_wt), .inh_wt(inh_wt), .thresh(thresh), .refr(refr),
    .en_p2m(en_p2m), .en_m2p(en_m2p), .en_inh(en_inh), .mode_mutual(mode_mutual),
    .map_spk(map_spk), .ptr_spk(ptr_spk), .inh_spk(inh_spk));

  // {sens, att, exp_map, exp_ptr, exp_inh}: thresh 100, refr 2, sens_wt 60, att_wt 100, all couplings off
  localparam logic [22:0] VEC [10] = '{
    {9'h001, 2'b00, 9'h000, 2'b00, 1'b0},
    {9'h001, 2'b00, 9'h001, 2'b00, 1'b0},
    {9'h001, 2'b00, 9'h000, 2'b00, 1'b0},
    {9'h001, 2'b00, 9'h000, 2'b00, 1'b0},
    {9'h001, 2'b00, 9'h000, 2'b00, 1'b0},
    {9'h003, 2'b00, 9'h001, 2'b00, 1'b0},
    {9'h002, 2'b00, 9'h002, 2'b00, 1'b0},
    {9'h000, 2'b01, 9'h000, 2'b01, 1'b0},
    {9'h000, 2'b11, 9'h000, 2'b10, 1'b0},
    {9'h000, 2'b00, 9'h000, 2'b00, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    sens_spk = '0; att_spk = '0; cfg_we = 1'b0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] c, input logic [7:0] s);
    cfg_we = 1'b1; cfg_idx = i; cfg_cos = c; cfg_sin = s;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic [8:0] s, input logic [1:0] a);
    sens_spk = s; att_spk = a;
    tick();
    sens_spk = '0; att_spk = '0;
  endtask

  initial begin
    int fires;
    @(negedge clk);
    do_reset();
    chk("R1 reset spikes", {map_spk, ptr_spk, inh_spk}, 12'h000);

    // R2 R4 R9 table: integration, threshold, refractory, no inhibition when disabled
    thresh = 12'd100; refr = 4'd2; sens_wt = 8'd60; att_wt = 8'd100;
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][22:14], VEC[i][13:12]);
      chk("R2/R4/R9 vector map", {3'b0, map_spk}, {3'b0, VEC[i][11:3]});
      chk("R2/R4 vector ptr", {10'b0, ptr_spk}, {10'b0, VEC[i][2:1]});
      chk("R2 vector inh", {11'b0, inh_spk}, {11'b0, VEC[i][0]});
    end

    // R5 R10: pointer-to-map coupling, out-of-range write ignored
    do_reset();
    refr = 4'd0; thresh = 12'd100; att_wt = 8'd100; en_p2m = 1'b1;
    wr(4'd3, 8'd100, 8'd40);
    wr(4'd5, 8'd30, 8'd100);
    wr(4'd11, 8'd255, 8'd255);
    step('0, 2'b01);
    chk("R5 ptr0 fires", {10'b0, ptr_spk}, 12'h001);
    step('0, 2'b10);
    chk("R5 cos weight map3", {3'b0, map_spk}, 12'h008);
    tick();
    chk("R5 R10 sin weight map5 only", {3'b0, map_spk}, 12'h020);
    // R9: p2m disabled, map3 holds 40 and must not fire on pointer 0 spike
    en_p2m = 1'b0;
    step('0, 2'b01);
    tick();
    chk("R9 p2m off no map spike", {3'b0, map_spk}, 12'h000);
    tick();
    chk("R9 p2m off still quiet", {3'b0, map_spk}, 12'h000);

    // R6: map-to-pointer coupling
    do_reset();
    en_m2p = 1'b1; sens_wt = 8'd100; thresh = 12'd100; refr = 4'd0;
    wr(4'd3, 8'd100, 8'd40);
    wr(4'd5, 8'd30, 8'd100);
    step(9'h008, 2'b00);
    chk("R6 map3 fires", {3'b0, map_spk}, 12'h008);
    tick();
    chk("R6 cos sum to ptr0", {10'b0, ptr_spk}, 12'h001);
    step(9'h020, 2'b00);
    tick();
    chk("R6 sin sum to ptr1", {10'b0, ptr_spk}, 12'h002);
    en_m2p = 1'b0;

    // R7: global inhibition clears all map neurons including sender
    do_reset();
    en_inh = 1'b1; mode_mutual = 1'b0; inh_wt = 8'd100; sens_wt = 8'd60;
    thresh = 12'd100; refr = 4'd0;
    step(9'h003, 2'b00);
    step(9'h001, 2'b00);
    chk("R7 sender fires", {3'b0, map_spk}, 12'h001);
    step(9'h005, 2'b00);
    chk("R7 inh neuron fires", {11'b0, inh_spk}, 12'h001);
    step(9'h002, 2'b00);
    chk("R7 clear blocks map1", {3'b0, map_spk}, 12'h000);
    step(9'h003, 2'b00);
    chk("R7 sender was cleared too", {3'b0, map_spk}, 12'h000);
    step(9'h003, 2'b00);
    chk("R7 both refire", {3'b0, map_spk}, 12'h003);

    // R8 R11: mutual inhibition spares sender
    do_reset();
    en_inh = 1'b1; mode_mutual = 1'b1; inh_wt = 8'd100;
    step(9'h003, 2'b00);
    step(9'h001, 2'b00);
    chk("R8 map0 fires", {3'b0, map_spk}, 12'h001);
    step(9'h003, 2'b00);
    chk("R8 map1 cleared", {3'b0, map_spk}, 12'h000);
    chk("R11 inh idle", {11'b0, inh_spk}, 12'h000);
    step(9'h003, 2'b00);
    chk("R8 sender kept its state", {3'b0, map_spk}, 12'h001);
    step(9'h002, 2'b00);
    step(9'h002, 2'b00);
    chk("R8 map1 restarted from zero", {3'b0, map_spk}, 12'h000);
    step(9'h002, 2'b00);
    chk("R8 map1 fires", {3'b0, map_spk}, 12'h002);
    chk("R11 inh still idle", {11'b0, inh_spk}, 12'h000);
    en_inh = 1'b0; mode_mutual = 1'b0;

    // R3: saturation at 4095
    do_reset();
    thresh = 12'd4095; sens_wt = 8'd255; refr = 4'd0;
    fires = 0;
    for (int i = 0; i < 16; i++) begin
      step(9'h010, 2'b00);
      if (map_spk[4]) fires++;
    end
    chk("R3 silent for 16 spikes", 12'(fires), 12'd0);
    step(9'h010, 2'b00);
    chk("R3 fires at saturation", {3'b0, map_spk}, 12'h010);

    // R4: refractory length 5
    do_reset();
    thresh = 12'd60; sens_wt = 8'd60; refr = 4'd5;
    step(9'h001, 2'b00);
    chk("R4 first spike", {3'b0, map_spk}, 12'h001);
    fires = 0;
    for (int i = 0; i < 5; i++) begin
      step(9'h001, 2'b00);
      if (map_spk[0]) fires++;
    end
    chk("R4 ignored during refractory", 12'(fires), 12'd0);
    step(9'h001, 2'b00);
    chk("R4 fires after refractory", {3'b0, map_spk}, 12'h001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule